// File: doc/BRIEF.md
# Beat-Frequency Period Meter

This block measures how far a stressed oscillator has drifted from a reference oscillator. It runs on the reference oscillator as its clock. On every rising edge it samples the level of the stressed oscillator, which gives a one-bit phase-comparison stream. When the two frequencies differ slightly, that stream is a slow square wave. Its period, the beat period, is the number of reference cycles the two oscillators need to slip by exactly one cycle against each other. A frequency shift of one percent therefore moves the measured count by a large fraction of its value, not by one percent.

The stream first passes through a short synchronizer. A sliding five-sample majority vote then removes jitter bubbles near the crossover points. An edge detector looks at five consecutive voted values and emits a one-cycle beat tick on each clean low-to-high transition. The tick copies the running cycle count into the output register and restarts the count. The output is an 8-bit period with a one-cycle valid strobe and an overflow flag. Counting is allowed while the `run` input is high. Dropping `run` clears the measurement state but leaves the last result visible.

Top module: `beat_period_meter`

## Requirements
- R1: While `rst` is high, and after it is released, `period_count`, `period_ovf`, `period_valid` and `beat_tick` are all 0 until a measurement completes.
- R2: `stress_in` is sampled on each rising edge of `clk` and is held between edges. The phase bit is 1 when the stressed signal is high at the instant the reference rises from low. For two free-running oscillators whose periods are 20 and 20.5 time units, every reported period is 41.
- R3: The voted bit is 1 when at least 3 of the 5 most recent phase bits are 1. Isolated 0 bubbles and adjacent 0 pairs inside a run of 1s (11011, 11001), and a lone 1 inside a run of 0s, neither add nor remove beat ticks and do not change the measured period.
- R4: `beat_tick` is a one-cycle pulse. It is raised when the five most recent voted values, oldest first, are 0,0,1,1,1, so each clean rising edge of the voted stream gives exactly one tick.
- R5: A reported `period_count` equals the number of `clk` cycles between the tick that started the measurement and the tick that ended it. This equals the period of a periodic phase stream.
- R6: The first tick after reset, or after `run` rises, only starts the count. Over n rising edges of the phase stream, exactly n-1 results are reported.
- R7: The edge detector ignores the voted stream until five samples have been collected after reset or after `run` rises. A stream that is high from the start produces no tick until it has gone low and risen again.
- R8: The count saturates at 255 and does not wrap. `period_ovf` is 1 exactly when the measured interval exceeded 255 cycles. An interval of exactly 255 reports 255 with `period_ovf` 0.
- R9: `period_valid` is a one-cycle pulse that coincides with `beat_tick`. `period_count` and `period_ovf` change only when `period_valid` is 1.
- R10: While `run` is 0, no tick or result is produced and the last reported values are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator, used as the block clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Measurement enable; low clears the measurement state |
| stress_in | input | 1 | Level of the stressed oscillator |
| beat_tick | output | 1 | One-cycle pulse per detected beat edge |
| period_valid | output | 1 | One-cycle strobe for a new result |
| period_count | output | CNT_W (8) | Last measured beat period in reference cycles |
| period_ovf | output | 1 | Last measured interval exceeded the count range |

## Verification
Some properties are checked on every cycle. Ticks are isolated pulses and never appear while the vote window is still filling. The counter sticks at its ceiling instead of wrapping. The valid strobe lasts one cycle, and the result and flag hold between strobes. A result below the ceiling never carries the overflow flag. Other behaviour shows only in the bench scenarios: the measured value matching the stream period, removal of bubbles, the discarded first partial period, the effect of `run`, and the exact 41-cycle beat of two free-running clocks.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
package bpm_pkg;
  // measurement state of the period counter
  typedef enum logic {
    ARM_IDLE = 1'b0,   // waiting for the first beat edge
    ARM_LIVE = 1'b1    // a beat edge has been seen, counting a full period
  } arm_state_t;

  // mask with the lowest n bits set, used to build the edge pattern
  function automatic logic [31:0] low_ones(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bpm_phase_sampler.sv
`timescale 1ns/1ps
module bpm_phase_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic din,
  output logic phase
);
  logic [STAGES-1:0] chain;

  // first stage takes the raw level at the reference rising edge
  always_ff @(posedge clk) begin
    if (rst || clr) chain[0] <= 1'b0;
    else            chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || clr) chain[g] <= 1'b0;
      else            chain[g] <= chain[g-1];
    end
  end

  assign phase = chain[STAGES-1];
endmodule

// File: rtl/bpm_vote_filter.sv
`timescale 1ns/1ps
module bpm_vote_filter #(
  parameter int VOTE_LEN  = 5,
  parameter int EDGE_LOW  = 2,
  parameter int EDGE_HIGH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic phase,
  output logic tick
);
  import bpm_pkg::*;

  localparam int EDGE_LEN = EDGE_LOW + EDGE_HIGH;
  localparam int THRESH   = VOTE_LEN / 2 + 1;
  localparam int FILL_W   = $clog2(VOTE_LEN + 1);
  localparam logic [FILL_W-1:0]   FILL_DONE = FILL_W'(VOTE_LEN);
  localparam logic [EDGE_LEN-1:0] EDGE_PAT  = EDGE_LEN'(low_ones(EDGE_HIGH));

  logic [VOTE_LEN-1:0] win;
  logic [FILL_W-1:0]   fill;
  logic [FILL_W-1:0]   ones;
  logic [EDGE_LEN-1:0] vhist;
  logic                filled;
  logic                voted;

  assign filled = (fill == FILL_DONE);

  // sliding window of the most recent phase bits
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win  <= '0;
      fill <= '0;
    end else begin
      win <= {win[VOTE_LEN-2:0], phase};
      if (!filled) fill <= fill + 1'b1;
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_LEN; i++) ones = ones + FILL_W'(win[i]);
  end

  assign voted = (ones >= FILL_W'(THRESH));

  // history of voted bits, preset high so start-up cannot look like an edge
  always_ff @(posedge clk) begin
    if (rst || clr)  vhist <= '1;
    else if (filled) vhist <= {vhist[EDGE_LEN-2:0], voted};
  end

  assign tick = (vhist == EDGE_PAT);

  assert_quiet_fill_R7: assert property (@(posedge clk) disable iff (rst)
    !filled |-> !tick);

  assert_tick_isolated_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> !tick);
endmodule

// File: rtl/bpm_period_counter.sv
`timescale 1ns/1ps
module bpm_period_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic             tick_q,
  output logic             valid_q,
  output logic [CNT_W-1:0] period_q,
  output logic             ovf_q
);
  import bpm_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  arm_state_t       arm;
  logic [CNT_W-1:0] cnt;
  logic             ovf_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm      <= ARM_IDLE;
      cnt      <= '0;
      ovf_flag <= 1'b0;
      tick_q   <= 1'b0;
      valid_q  <= 1'b0;
      period_q <= '0;
      ovf_q    <= 1'b0;
    end else if (clr) begin
      // measurement state cleared, last result kept
      arm      <= ARM_IDLE;
      cnt      <= '0;
      ovf_flag <= 1'b0;
      tick_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      tick_q  <= tick;
      valid_q <= tick && (arm == ARM_LIVE);
      if (tick) begin
        arm      <= ARM_LIVE;
        cnt      <= CNT_ONE;
        ovf_flag <= 1'b0;
        if (arm == ARM_LIVE) begin
          period_q <= cnt;
          ovf_q    <= ovf_flag;
        end
      end else if (cnt == CNT_MAX) begin
        ovf_flag <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  assert_ovf_only_at_max_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && period_q != CNT_MAX) |-> !ovf_q);

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  assert_hold_count_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> ($stable(period_q) && $stable(ovf_q)));

  assert_valid_with_tick_R9: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> tick_q);
endmodule

// File: rtl/beat_period_meter.sv
`timescale 1ns/1ps
module beat_period_meter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_LEN    = 5,
  parameter int EDGE_LOW    = 2,
  parameter int EDGE_HIGH   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             stress_in,
  output logic             beat_tick,
  output logic             period_valid,
  output logic [CNT_W-1:0] period_count,
  output logic             period_ovf
);
  logic clr;
  logic phase;
  logic tick;

  assign clr = !run;

  bpm_phase_sampler #(.STAGES(SYNC_STAGES)) u_sample (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .din  (stress_in),
    .phase(phase)
  );

  bpm_vote_filter #(
    .VOTE_LEN (VOTE_LEN),
    .EDGE_LOW (EDGE_LOW),
    .EDGE_HIGH(EDGE_HIGH)
  ) u_vote (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .phase(phase),
    .tick (tick)
  );

  bpm_period_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .tick    (tick),
    .tick_q  (beat_tick),
    .valid_q (period_valid),
    .period_q(period_count),
    .ovf_q   (period_ovf)
  );

  assert_idle_when_stopped_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!period_valid && !beat_tick));
endmodule

// File: tb/beat_period_meter_test.sv
`timescale 1ns/1ps
module beat_period_meter_test;
  localparam real CLK_NS = 20.0;
  localparam int  NV = 9;
  // vector table: period, low length, bubble kind, rising edges driven
  // bubble kind: 0 none, 1 single 0 in high run, 2 double 0 in high run, 3 single 1 in low run
  localparam int T_PER [NV] = '{12, 20, 24, 30,  9, 255, 256, 300, 64};
  localparam int T_LOW [NV] = '{ 6, 10, 10, 15,  4, 120, 120, 150, 20};
  localparam int T_BUB [NV] = '{ 0,  1,  2,  3,  0,   0,   0,   2,  1};
  localparam int T_NUM [NV] = '{ 6,  5,  5,  5,  6,   3,   3,   3,  4};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic drv = 1'b0;
  logic osc = 1'b0;
  logic use_osc = 1'b0;
  logic stress_in;
  logic beat_tick, period_valid, period_ovf;
  logic [7:0] period_count;

  int errors = 0;
  int checks = 0;
  int nvalid = 0;
  int nticks = 0;
  int hold_err = 0;
  int pair_err = 0;
  int check_en = 0;
  int exp_val = 0;
  int exp_ovf = 0;
  logic [7:0] last_cnt = '0;
  logic last_ovf = 1'b0;

  assign stress_in = use_osc ? osc : drv;

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    #0.3;
    forever #10.25 osc = ~osc;
  end

  beat_period_meter uut (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .stress_in   (stress_in),
    .beat_tick   (beat_tick),
    .period_valid(period_valid),
    .period_count(period_count),
    .period_ovf  (period_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (beat_tick) nticks++;
      if (period_valid) begin
        nvalid++;
        if (!beat_tick) pair_err++;
        if (check_en != 0) begin
          check(period_count == 8'(exp_val), "R5/R8 period", period_count, exp_val);
          check(period_ovf == exp_ovf[0], "R8 overflow flag", period_ovf, exp_ovf);
        end
      end else if (period_count != last_cnt || period_ovf != last_ovf) begin
        hold_err++;
      end
      last_cnt = period_count;
      last_ovf = period_ovf;
    end
  end

  task automatic restart();
    @(negedge clk); run = 1'b0; drv = 1'b0;
    @(negedge clk); run = 1'b1;
    nvalid = 0; nticks = 0;
  endtask

  task automatic drive_bits(input int per, input int low, input int bub, input int num);
    int mid;
    mid = low + (per - low) / 2;
    for (int k = 0; k < num; k++) begin
      for (int c = 0; c < per; c++) begin
        logic b;
        b = (c >= low);
        if (bub == 1 && c == mid) b = 1'b0;
        if (bub == 2 && (c == mid || c == mid + 1)) b = 1'b0;
        if (bub == 3 && c == low / 2) b = 1'b1;
        @(negedge clk); drv = b;
      end
    end
  endtask

  task automatic low_cycles(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); drv = 1'b0;
    end
  endtask

  task automatic run_entry(input int per, input int low, input int bub, input int num);
    exp_val = (per > 255) ? 255 : per;
    exp_ovf = (per > 255) ? 1 : 0;
    restart();
    check_en = 1;
    low_cycles(10);
    drive_bits(per, low, bub, num);
    low_cycles(low + 14);
    check_en = 0;
    // R6: first edge only arms; R3/R4: bubbles add no edges
    check(nvalid == num - 1, "R6 result count", nvalid, num - 1);
    check(nticks == num, "R3/R4 tick count", nticks, num);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(period_count == 8'd0 && !period_ovf && !period_valid && !beat_tick,
          "R1 outputs during reset", int'(period_count), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(period_count == 8'd0 && !period_ovf && !period_valid && !beat_tick,
          "R1 outputs after release", int'(period_count), 0);

    // R7: stream high from the start gives no tick
    restart();
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); drv = 1'b1;
    end
    check(nticks == 0, "R7 no tick on high start", nticks, 0);
    low_cycles(10);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); drv = 1'b1;
    end
    low_cycles(6);
    check(nticks == 1, "R7 first genuine edge", nticks, 1);
    check(nvalid == 0, "R6 no result after one edge", nvalid, 0);

    // table walk: R3, R4, R5, R6, R8
    for (int i = 0; i < NV; i++) begin
      run_entry(T_PER[i], T_LOW[i], T_BUB[i], T_NUM[i]);
    end

    // R10: run low ignores activity and holds the result
    begin
      logic [7:0] held;
      held = period_count;
      @(negedge clk); run = 1'b0;
      nvalid = 0; nticks = 0;
      drive_bits(10, 5, 0, 4);
      check(nvalid == 0 && nticks == 0, "R10 no activity while stopped", nvalid + nticks, 0);
      check(period_count == held, "R10 result held", period_count, held);
    end
    run_entry(16, 8, 0, 2);

    // R2: two free-running oscillators, beat of 41 reference cycles
    exp_val = 41; exp_ovf = 0;
    restart();
    use_osc = 1'b1;
    check_en = 1;
    repeat (41 * 9) @(negedge clk);
    check_en = 0;
    use_osc = 1'b0;
    check(nvalid >= 6, "R2 beat results seen", nvalid, 6);

    // R9: strobe pairing and hold between results over the whole run
    check(pair_err == 0, "R9 valid with tick", pair_err, 0);
    check(hold_err == 0, "R9 hold between results", hold_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule